// File: doc/BRIEF.md
# Complementary PWM Output Stage

This block turns one reference waveform into a pair of pin drives: a main output that follows the reference and a companion output that follows its inverse. Each pin has its own output-enable. Per-pin enable bits, polarity bits and idle levels, together with a master enable, decide for each pin whether it carries the waveform, sits in a parked off-state at its inactive level, or is released. Two off-state selection bits make that choice: one applies while the master enable is set (run), the other while it is clear (idle).

When both pins carry the waveform, each pin's change from inactive to active is held back by a programmable number of clock cycles. This dead-time keeps the two switches of a half-bridge from conducting together. A reference pulse shorter than the dead-time does not appear on the delayed pin at all. A break input clears the master enable at once, without waiting for a clock edge. The pins then go straight to their polarity levels, and after one dead-time interval of clock cycles they move to their programmed idle levels. Software sets and clears the master enable with single-cycle request pulses. A set request has no effect while break is held.

Top module: `cmp_out_stage`

## Requirements
- R1: After reset the master enable reads 0. With both pin enables, all polarity bits and the idle off-state bit at 0, all four pin outputs (both levels and both enables) are 0.
- R2: With master enable 1, the run off-state bit 0 and both pin enables 0, both pin levels and both pin enables are 0.
- R3: With master enable 1, the run off-state bit 1 and both pin enables 0, each pin level equals its polarity bit and both pin enables stay 0.
- R4: With master enable 1 and exactly one pin enable set, that pin has its enable at 1. Its level is the active signal XOR its polarity bit, where the active signal is the reference for the main pin and the inverted reference for the companion pin. No dead-time is applied.
- R5: In the single-pin case of R4, the unused pin is at level 0 with enable 0 when the run off-state bit is 0. When that bit is 1, the unused pin's level equals its polarity bit and its enable is 1.
- R6: With master enable 1 and both pin enables set, both pin enables are 1 regardless of the run off-state bit. Each pin's active signal rises only after it has been sampled active on dead_cnt consecutive clock edges, and it falls without delay. Each pin level is its delayed active signal XOR its polarity bit.
- R7: In the both-pin mode, an active pulse that lasts fewer than dead_cnt clock edges never reaches the pin.
- R8: With master enable 0, the run off-state bit has no effect. If the idle off-state bit is 0 or both pin enables are 0, both pin enables are 0 and each pin level equals its polarity bit as soon as the master enable drops.
- R9: With master enable 0, the idle off-state bit 1 and at least one pin enable set, both pin enables are 1 and each pin level equals its polarity bit as soon as the master enable drops.
- R10: While the master enable stays 0, each pin level changes to its idle-level bit after dead_cnt clock edges, counted from the first edge at which the master enable is 0. With dead_cnt 0 the change is immediate.
- R11: A high break input forces the master enable to 0 combinationally, in the same cycle. A set request given while break is high is ignored, and the master enable stays 0 after break is released until a new set request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_wave | input | 1 | Reference waveform, high = active |
| brk_in | input | 1 | Break: clears the master enable |
| arm_req | input | 1 | Pulse that sets the master enable |
| disarm_req | input | 1 | Pulse that clears the master enable |
| run_off_sel | input | 1 | Off-state selection while running |
| idle_off_sel | input | 1 | Off-state selection while idle |
| en_main | input | 1 | Main pin enable |
| en_comp | input | 1 | Companion pin enable |
| pol_main | input | 1 | Main pin polarity (1 = active low) |
| pol_comp | input | 1 | Companion pin polarity (1 = active low) |
| idle_main | input | 1 | Main pin idle level |
| idle_comp | input | 1 | Companion pin idle level |
| dead_cnt | input | 8 | Dead-time in clock cycles |
| out_main | output | 1 | Main pin level |
| oe_main | output | 1 | Main pin output-enable |
| out_comp | output | 1 | Companion pin level |
| oe_comp | output | 1 | Companion pin output-enable |
| master_en | output | 1 | Effective master enable |

## Verification
A dead-time counter that is stuck or off by one shows up on the first edge of the reference in the both-pin mode. The active-going pin then rises one clock early or late, or a short pulse leaks through, within dead_cnt + 1 cycles. A wrong idle counter moves the pins to their idle levels at the wrong edge after a break, and this is visible within dead_cnt + 1 cycles. A fault in the master-enable register shows at once as a master_en value that survives break or set requests it should not. Decode faults change the level or enable pattern in the same cycle as the control input that causes them.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int NPIN = 2;
  localparam int PIN_MAIN = 0;
  localparam int PIN_COMP = 1;

  // Per-pin drive choice in run mode
  typedef enum logic [1:0] {
    DRV_FLOAT = 2'd0,  // released, level 0
    DRV_PARK  = 2'd1,  // inactive level, enable depends on partner
    DRV_RAW   = 2'd2,  // waveform without dead-time
    DRV_PAIR  = 2'd3   // waveform with dead-time
  } drive_e;

  typedef struct packed {
    logic lvl;
    logic oe;
  } pin_t;
endpackage

// File: rtl/cos_deadtime.sv
module cos_deadtime #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_in,
  input  logic [CW-1:0] dt,
  output logic          act_out
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!act_in) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q < dt) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + {{(CW-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // rises after dt active samples, falls at once
  assign act_out = act_in && (cnt_q >= dt);
endmodule

// File: rtl/cos_idle_timer.sv
module cos_idle_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          live,
  input  logic [CW-1:0] dt,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (live) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q < dt) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + {{(CW-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = !live && (cnt_q >= dt);
endmodule

// File: rtl/cos_pin_mux.sv
module cos_pin_mux
  import cos_pkg::*;
(
  input  logic            live,
  input  logic            run_off,
  input  logic            idle_off,
  input  logic            idle_done,
  input  logic [NPIN-1:0] en,
  input  logic [NPIN-1:0] pol,
  input  logic [NPIN-1:0] idl,
  input  logic [NPIN-1:0] raw_act,
  input  logic [NPIN-1:0] dly_act,
  output pin_t [NPIN-1:0] pin
);
  logic pair_mode;
  logic any_en;

  assign pair_mode = &en;
  assign any_en    = |en;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    drive_e sel;
    logic   partner_en;

    assign partner_en = en[NPIN-1-i];

    always_comb begin
      if (pair_mode)    sel = DRV_PAIR;
      else if (en[i])   sel = DRV_RAW;
      else if (run_off) sel = DRV_PARK;
      else              sel = DRV_FLOAT;
    end

    always_comb begin
      if (!live) begin
        pin[i].lvl = idle_done ? idl[i] : pol[i];
        pin[i].oe  = idle_off && any_en;
      end else begin
        unique case (sel)
          DRV_PAIR:  begin pin[i].lvl = dly_act[i] ^ pol[i]; pin[i].oe = 1'b1;       end
          DRV_RAW:   begin pin[i].lvl = raw_act[i] ^ pol[i]; pin[i].oe = 1'b1;       end
          DRV_PARK:  begin pin[i].lvl = pol[i];              pin[i].oe = partner_en; end
          default:   begin pin[i].lvl = 1'b0;                pin[i].oe = 1'b0;       end
        endcase
      end
    end
  end
endmodule

// File: rtl/cmp_out_stage.sv
module cmp_out_stage
  import cos_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_wave,
  input  logic            brk_in,
  input  logic            arm_req,
  input  logic            disarm_req,
  input  logic            run_off_sel,
  input  logic            idle_off_sel,
  input  logic            en_main,
  input  logic            en_comp,
  input  logic            pol_main,
  input  logic            pol_comp,
  input  logic            idle_main,
  input  logic            idle_comp,
  input  logic [DT_W-1:0] dead_cnt,
  output logic            out_main,
  output logic            oe_main,
  output logic            out_comp,
  output logic            oe_comp,
  output logic            master_en
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // master enable register
  logic arm_q;
  logic arm_d;
  logic arm_en;

  always_comb begin
    arm_en = 1'b0;
    arm_d  = arm_q;
    if (brk_in) begin
      arm_en = 1'b1;
      arm_d  = 1'b0;
    end else if (arm_req) begin
      arm_en = 1'b1;
      arm_d  = 1'b1;
    end else if (disarm_req) begin
      arm_en = 1'b1;
      arm_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  arm_q <= 1'b0;
    else if (arm_en) arm_q <= arm_d;
  end

  logic live;
  assign live      = arm_q && !brk_in;
  assign master_en = live;

  // per-pin active signals
  logic [NPIN-1:0] raw_act;
  logic [NPIN-1:0] dly_act;
  assign raw_act[PIN_MAIN] = ref_wave;
  assign raw_act[PIN_COMP] = !ref_wave;

  for (genvar i = 0; i < NPIN; i++) begin : g_dt
    cos_deadtime #(.CW(DT_W)) u_dt (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .act_in  (raw_act[i]),
      .dt      (dead_cnt),
      .act_out (dly_act[i])
    );
  end

  logic idle_done;
  cos_idle_timer #(.CW(DT_W)) u_idle (
    .clk   (clk),
    .rst_n (rst_int_n),
    .live  (live),
    .dt    (dead_cnt),
    .done  (idle_done)
  );

  pin_t [NPIN-1:0] pin;
  cos_pin_mux u_mux (
    .live      (live),
    .run_off   (run_off_sel),
    .idle_off  (idle_off_sel),
    .idle_done (idle_done),
    .en        ({en_comp, en_main}),
    .pol       ({pol_comp, pol_main}),
    .idl       ({idle_comp, idle_main}),
    .raw_act   (raw_act),
    .dly_act   (dly_act),
    .pin       (pin)
  );

  assign out_main = pin[PIN_MAIN].lvl;
  assign oe_main  = pin[PIN_MAIN].oe;
  assign out_comp = pin[PIN_COMP].lvl;
  assign oe_comp  = pin[PIN_COMP].oe;
endmodule

// File: rtl/cmp_out_stage_chk.sv
module cmp_out_stage_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_wave,
  input logic brk_in,
  input logic idle_off_sel,
  input logic en_main,
  input logic en_comp,
  input logic pol_main,
  input logic pol_comp,
  input logic out_main,
  input logic oe_main,
  input logic out_comp,
  input logic oe_comp,
  input logic master_en
);
  a_r11_break_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    brk_in |-> !master_en);

  a_r11_break_holds: assert property (@(posedge clk) disable iff (!rst_n)
    brk_in |=> !master_en);

  a_r6_pair_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && en_main && en_comp) |-> (oe_main && oe_comp));

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && en_main && en_comp && !pol_main && !pol_comp) |-> !(out_main && out_comp));

  a_r4_single_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && en_main && !en_comp) |-> (out_main == (ref_wave ^ pol_main)));

  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_en && !idle_off_sel) |-> (!oe_main && !oe_comp));

  a_r2_unused_released: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && !en_main && !en_comp) |-> (!oe_main && !oe_comp));
endmodule

bind cmp_out_stage cmp_out_stage_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ref_wave     (ref_wave),
  .brk_in       (brk_in),
  .idle_off_sel (idle_off_sel),
  .en_main      (en_main),
  .en_comp      (en_comp),
  .pol_main     (pol_main),
  .pol_comp     (pol_comp),
  .out_main     (out_main),
  .oe_main      (oe_main),
  .out_comp     (out_comp),
  .oe_comp      (oe_comp),
  .master_en    (master_en)
);

// File: tb/cmp_out_stage_test.sv
module cmp_out_stage_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_wave, brk_in, arm_req, disarm_req;
  logic       run_off_sel, idle_off_sel, en_main, en_comp;
  logic       pol_main, pol_comp, idle_main, idle_comp;
  logic [7:0] dead_cnt;
  logic       out_main, oe_main, out_comp, oe_comp, master_en;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cmp_out_stage uut (
    .clk(clk), .rst_n(rst_n), .ref_wave(ref_wave), .brk_in(brk_in),
    .arm_req(arm_req), .disarm_req(disarm_req), .run_off_sel(run_off_sel),
    .idle_off_sel(idle_off_sel), .en_main(en_main), .en_comp(en_comp),
    .pol_main(pol_main), .pol_comp(pol_comp), .idle_main(idle_main),
    .idle_comp(idle_comp), .dead_cnt(dead_cnt), .out_main(out_main),
    .oe_main(oe_main), .out_comp(out_comp), .oe_comp(oe_comp),
    .master_en(master_en)
  );

  // {run_off, en_main, en_comp, pol_main, pol_comp, ref, exp out_main, oe_main, out_comp, oe_comp}
  localparam logic [9:0] VEC [11] = '{
    10'b0_00_00_1_0000,  // R2
    10'b1_00_11_1_1010,  // R3
    10'b0_10_00_1_1100,  // R4 R5
    10'b0_10_10_1_0100,  // R4
    10'b1_10_01_0_0111,  // R5
    10'b0_01_00_1_0001,  // R4
    10'b0_01_01_1_0011,  // R4
    10'b1_01_10_0_1111,  // R5
    10'b0_11_00_1_1101,  // R6
    10'b1_11_00_0_0111,  // R6
    10'b1_11_11_1_0111   // R6
  };

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [3:0] pins();
    return {out_main, oe_main, out_comp, oe_comp};
  endfunction

  task automatic do_arm();
    @(negedge clk) arm_req = 1'b1;
    @(negedge clk) arm_req = 1'b0;
    #2 chk("R11 arm", {3'b0, master_en}, 4'd1);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ref_wave = 0; brk_in = 0; arm_req = 0; disarm_req = 0;
    run_off_sel = 0; idle_off_sel = 0; en_main = 0; en_comp = 0;
    pol_main = 0; pol_comp = 0; idle_main = 0; idle_comp = 0; dead_cnt = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 master", {3'b0, master_en}, 4'd0);
    chk("R1 pins", pins(), 4'b0000);

    do_arm();

    // decode table, dead-time 0
    foreach (VEC[k]) begin
      @(negedge clk);
      {run_off_sel, en_main, en_comp, pol_main, pol_comp, ref_wave} = VEC[k][9:4];
      repeat (2) @(posedge clk);
      @(negedge clk);
      #2 chk($sformatf("R2-6 vec%0d", k), pins(), VEC[k][3:0]);
    end

    // R6 dead-time on both pins
    @(negedge clk);
    dead_cnt = 8'd4; en_main = 1; en_comp = 1; pol_main = 0; pol_comp = 0;
    run_off_sel = 0; ref_wave = 0;
    repeat (6) @(negedge clk);
    ref_wave = 1;
    #2 chk("R6 comp falls at once", {out_main, out_comp, 2'b00}, 4'b0000);
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); @(negedge clk);
      #2 chk($sformatf("R6 main edge%0d", k), {3'b0, out_main}, (k == 4) ? 4'd1 : 4'd0);
    end
    @(negedge clk) ref_wave = 0;
    #2 chk("R6 main falls at once", {out_main, out_comp, 2'b00}, 4'b0000);
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); @(negedge clk);
      #2 chk($sformatf("R6 comp edge%0d", k), {3'b0, out_comp}, (k == 4) ? 4'd1 : 4'd0);
    end

    // R7 short pulse suppressed
    @(negedge clk) ref_wave = 1;
    for (int k = 1; k <= 2; k++) begin
      @(posedge clk); @(negedge clk);
      #2 chk("R7 short pulse", {3'b0, out_main}, 4'd0);
    end
    ref_wave = 0;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); @(negedge clk);
      #2 chk("R7 after pulse", {3'b0, out_main}, 4'd0);
    end

    // R9 R10 R11 break into idle off-state
    @(negedge clk);
    dead_cnt = 8'd3; idle_off_sel = 1; idle_main = 1; idle_comp = 0;
    #3 brk_in = 1;
    #1 chk("R11 async drop", {3'b0, master_en}, 4'd0);
    chk("R9 parked at polarity", pins(), 4'b0101);
    for (int k = 1; k <= 3; k++) begin
      @(posedge clk); @(negedge clk);
      #2 chk($sformatf("R10 idle edge%0d", k), pins(), (k == 3) ? 4'b1101 : 4'b0101);
    end
    @(negedge clk) arm_req = 1;
    @(negedge clk) arm_req = 0;
    #2 chk("R11 arm ignored in break", {3'b0, master_en}, 4'd0);
    @(negedge clk) brk_in = 0;
    #2 chk("R11 stays clear", {3'b0, master_en}, 4'd0);
    chk("R11 pins still idle", pins(), 4'b1101);

    // R8 disarm with idle off-state bit clear
    do_arm();
    @(negedge clk);
    pol_main = 1; pol_comp = 1; idle_main = 0; idle_comp = 0;
    idle_off_sel = 0; run_off_sel = 1;
    @(negedge clk) disarm_req = 1;
    @(negedge clk) disarm_req = 0;
    #2 chk("R8 master clear", {3'b0, master_en}, 4'd0);
    chk("R8 released at polarity", pins(), 4'b1010);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2 chk("R10 idle levels released", pins(), 4'b0000);

    // R10 zero dead-time: idle levels at once
    @(negedge clk);
    pol_main = 0; pol_comp = 0; idle_main = 1; idle_comp = 0;
    idle_off_sel = 1; en_comp = 0; dead_cnt = 8'd0;
    do_arm();
    @(negedge clk) brk_in = 1;
    #2 chk("R10 zero dead-time", pins(), 4'b1101);
    @(negedge clk) brk_in = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule